// File: doc/BRIEF.md
# Bulk Read Payload Receiver

This block runs the data phase of a bulk read over a byte-serial link after the read command has already been issued and acknowledged elsewhere. Given a total byte count, it cuts the transfer into packets no larger than a configurable maximum. For every packet it first hunts for a start marker, pulling one byte at a time from the link shifter and discarding bytes until one arrives whose upper nibble is all ones. It then forwards exactly the packet's payload bytes to a byte-wide valid/ready stream. When the integrity trailer is enabled, it finally swallows two trailer bytes.

The shifter side is a simple pull handshake. The block raises `rx_ready` when it wants a byte, and a byte is consumed on any cycle where `rx_valid` and `rx_ready` are both high. While the payload stream is stalled, no byte is pulled. If the marker hunt sees a fixed number of non-marker bytes in a row, the transfer is abandoned: a one-cycle timeout pulse is raised and nothing further is pulled. A normal transfer ends with a one-cycle done pulse.

The controller is one state machine with six states: `S_IDLE`, `S_HUNT`, `S_PAYLOAD`, `S_TRAIL`, `S_DONE` and `S_FAIL`. Its transitions are:
- `S_IDLE` goes to `S_HUNT` on start with a non-zero size, or to `S_DONE` on start with size zero.
- `S_HUNT` goes to `S_PAYLOAD` on a marker byte, or to `S_FAIL` when the tries are used up.
- `S_PAYLOAD` goes, on the packet's last byte, to `S_TRAIL` if the trailer is enabled. Otherwise it goes to `S_DONE` when nothing remains, or to `S_HUNT` when more packets follow.
- `S_TRAIL` goes, on the second trailer byte, to `S_DONE` when nothing remains, or to `S_HUNT` when more packets follow.
- `S_DONE` and `S_FAIL` each return to `S_IDLE` after one cycle.

Top module: `spi_blkrd_rx`

## Requirements
- R1: After reset, `rx_ready`, `out_valid`, `done` and `timeout_err` are all low until `start` is pulsed.
- R2: Before each packet, bytes are consumed one at a time. The first byte with bits 7:4 equal to 4'b1111 is taken as the marker. Earlier bytes are discarded and never appear on the payload stream.
- R3: Each packet carries the smaller of the bytes still owed and `PKT_MAX`. The owed count drops by the packet size after each packet, and packets repeat until it reaches zero.
- R4: After a marker, exactly the packet's number of bytes are forwarded on `out_data`, unchanged and in arrival order.
- R5: With `crc_en` high at start, two bytes are consumed after every packet and discarded, whatever their value. This includes bytes whose upper nibble is all ones. With `crc_en` low, no trailer bytes are consumed.
- R6: During payload, `out_valid` follows `rx_valid`, and no byte is consumed in a cycle where `out_ready` is low.
- R7: If `HUNT_TRIES` consecutive non-marker bytes are consumed in one hunt, `timeout_err` pulses for one cycle. After that, no further byte is consumed or forwarded, and the block returns to idle. A marker arriving as try number `HUNT_TRIES` (that is, after `HUNT_TRIES`-1 non-marker bytes) is still accepted.
- R8: `done` pulses for exactly one cycle. It follows the second trailer byte of the final packet, or the final payload byte when the trailer is disabled. It never coincides with `timeout_err`.
- R9: A start with `total_size` equal to zero produces `done` without consuming any byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer (sampled in idle) |
| total_size | input | SIZE_W | Total payload bytes to receive |
| crc_en | input | 1 | Each packet is followed by a 2-byte trailer |
| rx_valid | input | 1 | Shifter has a byte available |
| rx_data | input | 8 | Byte from the shifter |
| rx_ready | output | 1 | Block requests a byte from the shifter |
| out_valid | output | 1 | Payload byte available |
| out_ready | input | 1 | Downstream accepts the payload byte |
| out_data | output | 8 | Payload byte |
| done | output | 1 | One-cycle pulse: transfer complete |
| timeout_err | output | 1 | One-cycle pulse: marker hunt exhausted, transfer aborted |

## Verification
Two functions can fall in the same cycle: a payload stall and a byte offered by the shifter. The bench provokes this by dropping `out_ready` on a rotating cycle pattern while the shifter keeps `rx_valid` high on most cycles. Every byte in the bench's stream is tagged as filler, marker, payload or trailer, and any payload-tagged byte consumed while `out_ready` is low is reported. The same sweep places trailer bytes carrying an all-ones upper nibble directly before the next hunt, so mistaking the trailer for a marker would shift the whole payload and break the byte comparison.

// File: rtl/spi_blkrd_pkg.sv
package spi_blkrd_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_HUNT,
        S_PAYLOAD,
        S_TRAIL,
        S_DONE,
        S_FAIL
    } blk_state_t;

    localparam logic [3:0] MARKER_NIBBLE = 4'hF;
endpackage

// File: rtl/spi_blkrd_pktsize.sv
module spi_blkrd_pktsize #(
    parameter int SIZE_W  = 24,
    parameter int PKT_MAX = 8192,
    localparam int PKT_W  = $clog2(PKT_MAX + 1)
) (
    input  logic [SIZE_W-1:0] owed,
    output logic [PKT_W-1:0]  pkt_len
);
    always_comb begin
        if (owed > SIZE_W'(PKT_MAX))
            pkt_len = PKT_W'(PKT_MAX);
        else
            pkt_len = owed[PKT_W-1:0];
    end
endmodule

// File: rtl/spi_blkrd_hunt.sv
module spi_blkrd_hunt
    import spi_blkrd_pkg::*;
#(
    parameter int HUNT_TRIES = 101,
    localparam int TRY_W     = $clog2(HUNT_TRIES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    input  logic [7:0] byte_in,
    output logic       is_marker,
    output logic       exhausted
);
    logic [TRY_W-1:0] tries;

    assign is_marker = (byte_in[7:4] == MARKER_NIBBLE);
    assign exhausted = step && !is_marker && (tries == TRY_W'(HUNT_TRIES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tries <= '0;
        else if (clear)
            tries <= '0;
        else if (step && !is_marker)
            tries <= tries + 1'b1;
    end
endmodule

// File: rtl/spi_blkrd_rx.sv
module spi_blkrd_rx
    import spi_blkrd_pkg::*;
#(
    parameter int SIZE_W     = 24,
    parameter int PKT_MAX    = 8192,
    parameter int HUNT_TRIES = 101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SIZE_W-1:0] total_size,
    input  logic              crc_en,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              done,
    output logic              timeout_err
);
    localparam int PKT_W = $clog2(PKT_MAX + 1);

    blk_state_t        state, state_nx;
    logic [SIZE_W-1:0] owed;
    logic [PKT_W-1:0]  pkt_left;
    logic [PKT_W-1:0]  pkt_len;
    logic              trl_second;
    logic              crc_q;
    logic              take;
    logic              is_marker;
    logic              exhausted;

    spi_blkrd_pktsize #(.SIZE_W(SIZE_W), .PKT_MAX(PKT_MAX)) u_pktsize (
        .owed    (owed),
        .pkt_len (pkt_len)
    );

    spi_blkrd_hunt #(.HUNT_TRIES(HUNT_TRIES)) u_hunt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state != S_HUNT),
        .step      (take && (state == S_HUNT)),
        .byte_in   (rx_data),
        .is_marker (is_marker),
        .exhausted (exhausted)
    );

    assign take = rx_valid && rx_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start)
                    state_nx = (total_size == '0) ? S_DONE : S_HUNT;
            end
            S_HUNT: begin
                if (take && is_marker)
                    state_nx = S_PAYLOAD;
                else if (exhausted)
                    state_nx = S_FAIL;
            end
            S_PAYLOAD: begin
                if (take && (pkt_left == PKT_W'(1))) begin
                    if (crc_q)
                        state_nx = S_TRAIL;
                    else if (owed == SIZE_W'(1))
                        state_nx = S_DONE;
                    else
                        state_nx = S_HUNT;
                end
            end
            S_TRAIL: begin
                if (take && trl_second)
                    state_nx = (owed == '0) ? S_DONE : S_HUNT;
            end
            S_DONE:  state_nx = S_IDLE;
            S_FAIL:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed       <= '0;
            pkt_left   <= '0;
            trl_second <= 1'b0;
            crc_q      <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    trl_second <= 1'b0;
                    if (start) begin
                        owed  <= total_size;
                        crc_q <= crc_en;
                    end
                end
                S_HUNT: begin
                    if (take && is_marker)
                        pkt_left <= pkt_len;
                end
                S_PAYLOAD: begin
                    if (take) begin
                        pkt_left <= pkt_left - 1'b1;
                        owed     <= owed - 1'b1;
                    end
                end
                S_TRAIL: begin
                    if (take)
                        trl_second <= !trl_second;
                end
                default: begin
                    trl_second <= 1'b0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        rx_ready    = 1'b0;
        out_valid   = 1'b0;
        done        = 1'b0;
        timeout_err = 1'b0;
        out_data    = rx_data;
        unique case (state)
            S_HUNT:    rx_ready = 1'b1;
            S_TRAIL:   rx_ready = 1'b1;
            S_PAYLOAD: begin
                rx_ready  = out_ready;
                out_valid = rx_valid;
            end
            S_DONE:    done = 1'b1;
            S_FAIL:    timeout_err = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/spi_blkrd_rx_chk.sv
module spi_blkrd_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_ready,
    input logic out_valid,
    input logic out_ready,
    input logic done,
    input logic timeout_err
);
    assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !(rx_valid && rx_ready))
        else $error("R6 byte consumed during stall");

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("R8 done longer than one cycle");

    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout_err))
        else $error("R8 done with timeout");

    assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (!rx_ready && !out_valid))
        else $error("R7 activity during abort");

    assert_timeout_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err)
        else $error("R7 timeout longer than one cycle");

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rx_ready && !out_valid))
        else $error("R8 activity with done");
endmodule

bind spi_blkrd_rx spi_blkrd_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .done        (done),
    .timeout_err (timeout_err)
);

// File: tb/spi_blkrd_rx_test.sv
`timescale 1ns/1ps
module spi_blkrd_rx_test;
    localparam int SW = 8;
    localparam int PM = 4;
    localparam int HT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] total_size = '0;
    logic          crc_en = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_ready;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;
    logic          done;
    logic          timeout_err;

    int errors = 0;
    int checks = 0;

    logic [7:0] strm [0:255];
    int         kind [0:255];   // 0 filler/marker, 1 payload, 2 trailer
    logic [7:0] expv [0:63];
    int slen, nexp;

    always #2.5 clk = ~clk;

    spi_blkrd_rx #(.SIZE_W(SW), .PKT_MAX(PM), .HUNT_TRIES(HT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .total_size(total_size),
        .crc_en(crc_en), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done), .timeout_err(timeout_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Build the shifter stream; fail_pkt < 0 means no abort
    task automatic build(input int total, input bit crc, input int seed, input int fail_pkt);
        int rem, p, idx;
        rem = total; p = 0; idx = 0; slen = 0; nexp = 0;
        while (rem > 0) begin
            int n, nf;
            n  = (rem < PM) ? rem : PM;
            nf = (seed + p) % HT;
            if (p == fail_pkt) nf = HT;
            for (int f = 0; f < nf; f++) begin
                strm[slen] = (f % 3 == 0) ? 8'h00 : ((f % 3 == 1) ? 8'hE7 : 8'h7F);
                kind[slen] = 0; slen++;
            end
            if (p == fail_pkt) return;
            strm[slen] = 8'hF0 | 8'(p); kind[slen] = 0; slen++;
            for (int b = 0; b < n; b++) begin
                strm[slen] = 8'(idx * 13 + total * 5 + 3);
                kind[slen] = 1;
                expv[nexp] = strm[slen];
                slen++; nexp++; idx++;
            end
            if (crc) begin
                strm[slen] = 8'hF5; kind[slen] = 2; slen++;
                strm[slen] = 8'hFF; kind[slen] = 2; slen++;
            end
            rem -= n; p++;
        end
    endtask

    task automatic run(input int total, input bit crc, input int seed, input int fail_pkt);
        int ptr, nout, bad, ndone, nto, stallbad, cyc, quiet;
        bit fin;
        build(total, crc, seed, fail_pkt);
        ptr = 0; nout = 0; bad = 0; ndone = 0; nto = 0; stallbad = 0; fin = 0;
        @(negedge clk);
        total_size = SW'(total); crc_en = crc; start = 1'b1;
        rx_valid = 1'b0; out_ready = 1'b1;
        @(posedge clk);
        cyc = 0;
        while (!fin && cyc < 1000) begin
            @(negedge clk);
            start     = 1'b0;
            rx_valid  = (ptr < slen) && ((cyc + seed) % 7 != 3);
            rx_data   = (ptr < slen) ? strm[ptr] : 8'h00;
            out_ready = ((cyc * 3 + seed) % 5) != 1;
            #1;
            if (done) begin ndone++; fin = 1; end
            if (timeout_err) begin nto++; fin = 1; end
            if (out_valid && out_ready) begin
                if (nout >= nexp || out_data != expv[nout]) bad++;
                nout++;
            end
            if (rx_valid && rx_ready) begin
                if (kind[ptr] == 1 && !out_ready) stallbad++;
                ptr++;
            end
            @(posedge clk);
            cyc++;
        end
        quiet = 0;
        for (int q = 0; q < 3; q++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'hF1; out_ready = 1'b1;
            #1;
            if (rx_ready || out_valid || done || timeout_err) quiet++;
        end
        rx_valid = 1'b0;
        // R3/R4: payload count and content
        check(nout == nexp, "R3 payload byte count", nout, nexp);
        check(bad == 0, "R4 payload byte mismatches", bad, 0);
        // R2/R5: stream consumed exactly (fillers, marker, trailer)
        check(ptr == slen, "R2/R5 bytes consumed", ptr, slen);
        check(stallbad == 0, "R6 payload byte taken while stalled", stallbad, 0);
        if (fail_pkt < 0) begin
            check(ndone == 1, "R8 done pulses", ndone, 1);
            check(nto == 0, "R8 no timeout", nto, 0);
        end else begin
            check(nto == 1, "R7 timeout pulses", nto, 1);
            check(ndone == 0, "R7 no done after abort", ndone, 0);
        end
        check(quiet == 0, "R7/R8 idle after end", quiet, 0);
        if (total == 0) check(ptr == 0, "R9 zero size consumes nothing", ptr, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!rx_ready && !out_valid && !done && !timeout_err, "R1 in reset", 1, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'hF0; out_ready = 1'b1;
        #1;
        check(!rx_ready && !out_valid && !done && !timeout_err, "R1 idle after reset", 1, 0);
        rx_valid = 1'b0;
        // R2..R5, R8, R9: sweep sizes, trailer mode and filler pattern
        for (int t = 0; t <= 9; t++)
            for (int c = 0; c < 2; c++)
                for (int s = 0; s < 3; s++)
                    run(t, c[0], s, -1);
        // R7: abort in each packet position
        for (int t = 1; t <= 9; t += 4)
            for (int c = 0; c < 2; c++)
                for (int f = 0; f <= (t - 1) / PM; f++)
                    run(t, c[0], 1, f);
        // R7 boundary: HT-1 fillers before a marker still accepted (seed = HT-1)
        run(3, 1'b0, HT - 1, -1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule